// File: doc/BRIEF.md
# Split-Operand FPU Reservation Merge Stage

This stage sits in front of three floating-point execution pipes: add, multiply and move/detect. Each floating-point operation reaches it as two consecutive half-dispatches. The first is a fill half that carries the low 32 bits of operands A and B. The second carries the high 32 bits of both operands, the 6-bit opcode and a 2-bit source tag for each operand. The stage joins the two halves into one 64-bit-operand entry and holds it in a single issue slot.

Before issue, the entry's operands are put into the internal format. An operand forwarded from the output of an FPU pipe is already in that format and is used unchanged. Any other operand, from the register file or from another unit, passes through one registered conversion cycle. Here the conversion is modelled as an XOR with a constant mask. The entry then goes to exactly one pipe, chosen by its opcode, and waits there under a valid/ready handshake. The add pipe can also stretch its acceptance by one or more cycles when a cancelled result needs renormalising.

Top module: `fprs_merge`

## Requirements
- R1: After reset, `in_ready` is 1, `iss_sel` is 3'b000, all three pipe valids are 0 and `pair_err` is 0.
- R2: An issued entry carries A = {A high half, A low half} and B = {B high half, B low half}, taken from the fill half and the following second half, with the opcode taken from the second half.
- R3: When both source tags of the second half are 2'b10 (FPU forward), the entry is offered in the cycle right after the clock edge that accepts the second half, with both operands unconverted.
- R4: When either tag is 2'b00 (register file), 2'b01 (other unit) or 2'b11, the entry is offered one cycle later. Each operand whose tag is not 2'b10 is XORed with CONV_MASK (default 64'h7FF0_0000_0000_0000), and a forwarded operand is left unchanged.
- R5: Routing uses opcode bits [5:4]. 2'b00 selects add (`iss_sel` = 3'b001), 2'b01 selects multiply (3'b010), and 2'b10 or 2'b11 selects move/detect (3'b100). `iss_sel` is never anything other than one-hot or zero.
- R6: An offered entry keeps its operands, opcode and select unchanged until the selected pipe's ready is high while its valid is high. It leaves at that edge, and `in_ready` is 1 in the following cycle.
- R7: While `add_extend` is 1, `add_valid` is 0 and a held add entry stays in the slot.
- R8: A second half accepted with no pending fill half is dropped, and `pair_err` is 1 for one cycle after the accepting edge.
- R9: A fill half accepted while another fill half is pending replaces it, and `pair_err` is 1 in the following cycle. A later second half then pairs with the newer fill.
- R10: While an entry occupies the slot (converting or offered), `in_ready` is 0 and the stage ignores any half presented on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A half-dispatch is presented |
| in_fill | input | 1 | 1 = fill (low) half, 0 = second (high) half |
| in_a_half | input | 32 | Operand A half |
| in_b_half | input | 32 | Operand B half |
| in_opcode | input | 6 | Opcode, used on the second half |
| in_a_src | input | 2 | Operand A source tag, used on the second half |
| in_b_src | input | 2 | Operand B source tag, used on the second half |
| in_ready | output | 1 | The stage can take a half this cycle |
| iss_a | output | 64 | Issued operand A |
| iss_b | output | 64 | Issued operand B |
| iss_op | output | 6 | Issued opcode |
| iss_sel | output | 3 | One-hot pipe select: bit0 add, bit1 mul, bit2 move/detect |
| add_valid | output | 1 | Entry offered to the add pipe |
| add_ready | input | 1 | Add pipe accepts |
| add_extend | input | 1 | Add pipe needs an extra normalise cycle |
| mul_valid | output | 1 | Entry offered to the multiply pipe |
| mul_ready | input | 1 | Multiply pipe accepts |
| mv_valid | output | 1 | Entry offered to the move/detect pipe |
| mv_ready | input | 1 | Move/detect pipe accepts |
| pair_err | output | 1 | Pairing error pulse |

## Verification
Inputs are driven on falling edges and outputs are sampled on the next falling edge, which lies half a period after the rising edge that took the input. A pairing error is due at that first sample. A fully forwarded entry is due there too, while an entry that needs conversion must still be absent at that sample and present one sample later, so the bench checks both points to measure the latency exactly. Slot release is checked one sample after the cycle in which ready is raised.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

    localparam int HALF_W = 32;
    localparam int OPR_W  = 2 * HALF_W;
    localparam int OPC_W  = 6;
    localparam int TAG_W  = 2;
    localparam int N_OPND = 2;
    localparam int N_PIPE = 3;

    localparam logic [TAG_W-1:0] SRC_REGF = 2'b00;
    localparam logic [TAG_W-1:0] SRC_XUNT = 2'b01;
    localparam logic [TAG_W-1:0] SRC_FWD  = 2'b10;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_CONV  = 2'd1,
        SLOT_ISSUE = 2'd2
    } slot_e;

    typedef struct packed {
        logic [HALF_W-1:0] a_lo;
        logic [HALF_W-1:0] b_lo;
    } fill_t;

    typedef struct packed {
        logic [N_OPND-1:0][OPR_W-1:0] opnd;
        logic [N_OPND-1:0][TAG_W-1:0] src;
        logic [OPC_W-1:0]             op;
    } entry_t;

    function automatic logic [N_PIPE-1:0] pipe_of(input logic [OPC_W-1:0] op);
        case (op[OPC_W-1 -: 2])
            2'b00:   return 3'b001;
            2'b01:   return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic all_fwd(input logic [N_OPND-1:0][TAG_W-1:0] src);
        logic r;
        r = 1'b1;
        for (int i = 0; i < N_OPND; i++) r = r & (src[i] == SRC_FWD);
        return r;
    endfunction

endpackage

// File: rtl/fprs_pair_latch.sv
module fprs_pair_latch
    import fprs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_fill,
    input  logic  take_second,
    input  fill_t fill_in,
    output logic  pend_vld,
    output fill_t pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend_q   <= '0;
        end else if (take_fill) begin
            pend_vld <= 1'b1;
            pend_q   <= fill_in;
        end else if (take_second) begin
            pend_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/fprs_convert.sv
module fprs_convert
    import fprs_pkg::*;
#(
    parameter logic [OPR_W-1:0] MASK = 64'h7FF0_0000_0000_0000
) (
    input  logic [OPR_W-1:0] raw,
    input  logic             skip,
    output logic [OPR_W-1:0] cooked
);
    always_comb begin
        cooked = skip ? raw : (raw ^ MASK);
    end
endmodule

// File: rtl/fprs_issue_slot.sv
module fprs_issue_slot
    import fprs_pkg::*;
#(
    parameter logic [OPR_W-1:0] CONV_MASK = 64'h7FF0_0000_0000_0000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  entry_t load_ent,
    input  logic   accept,
    output entry_t ent_q,
    output slot_e  st_q
);
    logic [N_OPND-1:0][OPR_W-1:0] cooked;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cv
        fprs_convert #(.MASK(CONV_MASK)) u_cv (
            .raw    (ent_q.opnd[g]),
            .skip   (ent_q.src[g] == SRC_FWD),
            .cooked (cooked[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SLOT_EMPTY;
            ent_q <= '0;
        end else begin
            case (st_q)
                SLOT_EMPTY: begin
                    if (load) begin
                        ent_q <= load_ent;
                        st_q  <= all_fwd(load_ent.src) ? SLOT_ISSUE : SLOT_CONV;
                    end
                end
                SLOT_CONV: begin
                    ent_q.opnd <= cooked;
                    st_q       <= SLOT_ISSUE;
                end
                SLOT_ISSUE: begin
                    if (accept) st_q <= SLOT_EMPTY;
                end
                default: st_q <= SLOT_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/fprs_merge.sv
module fprs_merge
    import fprs_pkg::*;
#(
    parameter logic [OPR_W-1:0] CONV_MASK = 64'h7FF0_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fill,
    input  logic [HALF_W-1:0] in_a_half,
    input  logic [HALF_W-1:0] in_b_half,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [TAG_W-1:0]  in_a_src,
    input  logic [TAG_W-1:0]  in_b_src,
    output logic              in_ready,
    output logic [OPR_W-1:0]  iss_a,
    output logic [OPR_W-1:0]  iss_b,
    output logic [OPC_W-1:0]  iss_op,
    output logic [N_PIPE-1:0] iss_sel,
    output logic              add_valid,
    input  logic              add_ready,
    input  logic              add_extend,
    output logic              mul_valid,
    input  logic              mul_ready,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic              pair_err
);
    logic        take, take_fill, take_second, load, accept, offered;
    logic        pend_vld;
    fill_t       pend_q, fill_in;
    entry_t      new_ent, ent_q;
    slot_e       st_q;
    logic [N_PIPE-1:0] route;

    assign take        = in_valid && in_ready;
    assign take_fill   = take && in_fill;
    assign take_second = take && !in_fill;
    assign load        = take_second && pend_vld;
    assign fill_in     = '{a_lo: in_a_half, b_lo: in_b_half};

    fprs_pair_latch u_pair (
        .clk         (clk),
        .rst         (rst),
        .take_fill   (take_fill),
        .take_second (take_second),
        .fill_in     (fill_in),
        .pend_vld    (pend_vld),
        .pend_q      (pend_q)
    );

    always_comb begin
        new_ent         = '0;
        new_ent.opnd[0] = {in_a_half, pend_q.a_lo};
        new_ent.opnd[1] = {in_b_half, pend_q.b_lo};
        new_ent.src[0]  = in_a_src;
        new_ent.src[1]  = in_b_src;
        new_ent.op      = in_opcode;
    end

    fprs_issue_slot #(.CONV_MASK(CONV_MASK)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_ent (new_ent),
        .accept   (accept),
        .ent_q    (ent_q),
        .st_q     (st_q)
    );

    assign in_ready  = (st_q == SLOT_EMPTY);
    assign offered   = (st_q == SLOT_ISSUE);
    assign route     = pipe_of(ent_q.op);
    assign iss_sel   = offered ? route : '0;
    assign iss_a     = ent_q.opnd[0];
    assign iss_b     = ent_q.opnd[1];
    assign iss_op    = ent_q.op;
    assign add_valid = iss_sel[0] && !add_extend;
    assign mul_valid = iss_sel[1];
    assign mv_valid  = iss_sel[2];
    assign accept    = (add_valid && add_ready) || (mul_valid && mul_ready)
                     || (mv_valid && mv_ready);

    always_ff @(posedge clk) begin
        if (rst) pair_err <= 1'b0;
        else     pair_err <= (take_fill && pend_vld) || (take_second && !pend_vld);
    end
endmodule

// File: rtl/fprs_merge_chk.sv
module fprs_merge_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_fill,
    input logic        in_ready,
    input logic [1:0]  in_a_src,
    input logic [1:0]  in_b_src,
    input logic        pend_vld,
    input logic [2:0]  iss_sel,
    input logic [63:0] iss_a,
    input logic [63:0] iss_b,
    input logic        add_valid,
    input logic        add_ready,
    input logic        add_extend,
    input logic        mul_valid,
    input logic        mul_ready,
    input logic        mv_valid,
    input logic        mv_ready,
    input logic        pair_err
);
    logic fire, sec_ok, both_fwd;
    assign fire     = (add_valid && add_ready) || (mul_valid && mul_ready) || (mv_valid && mv_ready);
    assign sec_ok   = in_valid && in_ready && !in_fill && pend_vld;
    assign both_fwd = (in_a_src == 2'b10) && (in_b_src == 2'b10);

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(iss_sel));
    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (rst) (|iss_sel) |-> !in_ready);
    // R7
    add_extend_chk: assert property (@(posedge clk) disable iff (rst) add_extend |-> !add_valid);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((|iss_sel) && !fire) |=> ($stable(iss_a) && $stable(iss_b) && $stable(iss_sel)));
    // R3
    fwd_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_ok && both_fwd) |=> (|iss_sel));
    // R4
    conv_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_ok && !both_fwd) |=> ((iss_sel == 3'b000) && !in_ready));
    // R8
    orphan_err_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_fill && !pend_vld) |=> pair_err);
endmodule

bind fprs_merge fprs_merge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_fill    (in_fill),
    .in_ready   (in_ready),
    .in_a_src   (in_a_src),
    .in_b_src   (in_b_src),
    .pend_vld   (pend_vld),
    .iss_sel    (iss_sel),
    .iss_a      (iss_a),
    .iss_b      (iss_b),
    .add_valid  (add_valid),
    .add_ready  (add_ready),
    .add_extend (add_extend),
    .mul_valid  (mul_valid),
    .mul_ready  (mul_ready),
    .mv_valid   (mv_valid),
    .mv_ready   (mv_ready),
    .pair_err   (pair_err)
);

// File: tb/fprs_merge_test.sv
module fprs_merge_test;
    localparam logic [63:0] MASK = 64'h7FF0_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_fill;
    logic [31:0] in_a_half, in_b_half;
    logic [5:0]  in_opcode;
    logic [1:0]  in_a_src, in_b_src;
    logic        in_ready;
    logic [63:0] iss_a, iss_b;
    logic [5:0]  iss_op;
    logic [2:0]  iss_sel;
    logic        add_valid, add_ready, add_extend;
    logic        mul_valid, mul_ready, mv_valid, mv_ready, pair_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fprs_merge #(.CONV_MASK(MASK)) uut (.*);

    typedef struct packed {
        logic [31:0] a_lo, b_lo, a_hi, b_hi;
        logic [5:0]  op;
        logic [1:0]  as, bs;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h1111_1111, 32'h2222_2222, 32'h3FF0_0000, 32'h4000_0000, 6'h02, 2'b10, 2'b10},
        '{32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hC008_0000, 32'h3FE0_1234, 6'h13, 2'b00, 2'b01},
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h7FF8_0000, 32'h8000_0000, 6'h21, 2'b10, 2'b00},
        '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0123_4567, 32'h89AB_CDEF, 6'h3A, 2'b01, 2'b10},
        '{32'h1357_9BDF, 32'h2468_ACE0, 32'h4010_0000, 32'hC010_0000, 6'h0F, 2'b01, 2'b01},
        '{32'hCAFE_0000, 32'h0000_CAFE, 32'h3FF8_8888, 32'h4008_7777, 6'h1C, 2'b10, 2'b10}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_half(input logic fill, input logic [31:0] a, input logic [31:0] b,
                              input logic [5:0] op, input logic [1:0] as, input logic [1:0] bs);
        in_valid = 1'b1; in_fill = fill; in_a_half = a; in_b_half = b;
        in_opcode = op; in_a_src = as; in_b_src = bs;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [2:0] exp_sel(input logic [5:0] op);
        case (op[5:4])
            2'b00: return 3'b001;
            2'b01: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    task automatic release_entry(input logic [2:0] sel);
        add_ready = sel[0]; mul_ready = sel[1]; mv_ready = sel[2];
        @(negedge clk);
        add_ready = 1'b0; mul_ready = 1'b0; mv_ready = 1'b0;
        check(in_ready === 1'b1, "R6 slot free after accept", {63'd0, in_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_fill = 1'b0; in_a_half = '0; in_b_half = '0;
        in_opcode = '0; in_a_src = '0; in_b_src = '0;
        add_ready = 1'b0; add_extend = 1'b0; mul_ready = 1'b0; mv_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(in_ready === 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
        check(iss_sel === 3'b000, "R1 iss_sel", {61'd0, iss_sel}, 64'd0);
        check({add_valid, mul_valid, mv_valid} === 3'b000, "R1 valids",
              {61'd0, add_valid, mul_valid, mv_valid}, 64'd0);
        check(pair_err === 1'b0, "R1 pair_err", {63'd0, pair_err}, 64'd0);

        // Table walk: R2 R3 R4 R5
        foreach (VECS[i]) begin
            vec_t v;
            logic [63:0] ea, eb;
            logic [2:0]  es;
            bit fast;
            v    = VECS[i];
            fast = (v.as == 2'b10) && (v.bs == 2'b10);
            ea   = {v.a_hi, v.a_lo} ^ ((v.as == 2'b10) ? 64'd0 : MASK);
            eb   = {v.b_hi, v.b_lo} ^ ((v.bs == 2'b10) ? 64'd0 : MASK);
            es   = exp_sel(v.op);
            drive_half(1'b1, v.a_lo, v.b_lo, 6'h00, 2'b00, 2'b00);
            drive_half(1'b0, v.a_hi, v.b_hi, v.op, v.as, v.bs);
            if (fast) begin
                check(iss_sel === es, "R3 forwarded entry offered at once", {61'd0, iss_sel}, {61'd0, es});
            end else begin
                check(iss_sel === 3'b000, "R4 converted entry not yet offered", {61'd0, iss_sel}, 64'd0);
                check(in_ready === 1'b0, "R10 busy while converting", {63'd0, in_ready}, 64'd0);
                @(negedge clk);
                check(iss_sel === es, "R4 converted entry offered", {61'd0, iss_sel}, {61'd0, es});
            end
            check(iss_a === ea, "R2 R4 operand A", iss_a, ea);
            check(iss_b === eb, "R2 R4 operand B", iss_b, eb);
            check(iss_op === v.op, "R2 opcode", {58'd0, iss_op}, {58'd0, v.op});
            check({mv_valid, mul_valid, add_valid} === es, "R5 pipe valid", {61'd0, mv_valid, mul_valid, add_valid}, {61'd0, es});
            release_entry(es);
        end

        // R6 hold while not ready, also R10 input ignored while busy
        drive_half(1'b1, 32'h0000_00AA, 32'h0000_00BB, 6'h00, 2'b00, 2'b00);
        drive_half(1'b0, 32'h4000_0001, 32'h4000_0002, 6'h25, 2'b10, 2'b10);
        drive_half(1'b1, 32'hFFFF_0000, 32'hEEEE_0000, 6'h00, 2'b00, 2'b00);
        drive_half(1'b0, 32'h1234_0000, 32'h5678_0000, 6'h05, 2'b10, 2'b10);
        repeat (2) @(negedge clk);
        check(iss_a === 64'h4000_0001_0000_00AA, "R6 operand A held", iss_a, 64'h4000_0001_0000_00AA);
        check(iss_sel === 3'b100, "R6 select held", {61'd0, iss_sel}, 64'd4);
        check(pair_err === 1'b0, "R10 busy input raised no error", {63'd0, pair_err}, 64'd0);
        release_entry(3'b100);
        repeat (2) @(negedge clk);
        check(iss_sel === 3'b000, "R10 ignored halves left no entry", {61'd0, iss_sel}, 64'd0);

        // R8 orphan second half
        drive_half(1'b0, 32'h1, 32'h2, 6'h00, 2'b10, 2'b10);
        check(pair_err === 1'b1, "R8 orphan error", {63'd0, pair_err}, 64'd1);
        check(iss_sel === 3'b000, "R8 orphan dropped", {61'd0, iss_sel}, 64'd0);
        @(negedge clk);
        check(pair_err === 1'b0, "R8 error one cycle", {63'd0, pair_err}, 64'd0);
        check(iss_sel === 3'b000, "R8 orphan still absent", {61'd0, iss_sel}, 64'd0);

        // R9 fill overwrite
        drive_half(1'b1, 32'h0BAD_0BAD, 32'h0BAD_0BAD, 6'h00, 2'b00, 2'b00);
        check(pair_err === 1'b0, "R9 first fill no error", {63'd0, pair_err}, 64'd0);
        drive_half(1'b1, 32'h600D_0001, 32'h600D_0002, 6'h00, 2'b00, 2'b00);
        check(pair_err === 1'b1, "R9 overwrite error", {63'd0, pair_err}, 64'd1);
        drive_half(1'b0, 32'h0000_0003, 32'h0000_0004, 6'h11, 2'b10, 2'b10);
        check(iss_a === 64'h0000_0003_600D_0001, "R9 newer fill used A", iss_a, 64'h0000_0003_600D_0001);
        check(iss_b === 64'h0000_0004_600D_0002, "R9 newer fill used B", iss_b, 64'h0000_0004_600D_0002);
        release_entry(3'b010);

        // R7 add extend
        drive_half(1'b1, 32'h0, 32'h0, 6'h00, 2'b00, 2'b00);
        add_extend = 1'b1; add_ready = 1'b1;
        drive_half(1'b0, 32'h3FF0_0000, 32'hBFF0_0000, 6'h01, 2'b10, 2'b10);
        check(add_valid === 1'b0, "R7 add_valid low during extend", {63'd0, add_valid}, 64'd0);
        @(negedge clk);
        check(iss_sel === 3'b001, "R7 add entry held during extend", {61'd0, iss_sel}, 64'd1);
        check(in_ready === 1'b0, "R7 slot still busy", {63'd0, in_ready}, 64'd0);
        add_extend = 1'b0;
        #1;
        check(add_valid === 1'b1, "R7 add_valid after extend", {63'd0, add_valid}, 64'd1);
        @(negedge clk);
        add_ready = 1'b0;
        check(in_ready === 1'b1, "R7 released after extend", {63'd0, in_ready}, 64'd1);

        // R1 reset clears a pending entry
        drive_half(1'b1, 32'h9, 32'h9, 6'h00, 2'b00, 2'b00);
        drive_half(1'b0, 32'h9, 32'h9, 6'h00, 2'b00, 2'b00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(in_ready === 1'b1 && iss_sel === 3'b000, "R1 reset mid-flight",
              {60'd0, in_ready, iss_sel}, 64'h8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule